// File: doc/BRIEF.md
# Byte Parity Checker and Generator

This block is the parity unit of one 36-bit bidirectional data port. The port word is made of four 9-bit bytes. In every byte the top bit carries parity for the eight bits below it. Words arriving on the port are checked byte by byte, and a registered active-low flag reports whether any byte failed. Words leaving the port on a read can have the top bit of each byte replaced by a freshly generated parity bit. A single select input picks odd or even parity, and that choice applies to both the check and the generation.

The checking trees double as the generator for mailbox reads. When the port is set up for a mailbox read with generation switched on, those trees are busy with the outgoing mailbox word and cannot judge the incoming pins. In that case the error flag is forced to its inactive (high) level. Ordinary reads from the queue get their parity from a second, dedicated set of trees, so they do not disturb checking.

Top module: `byte_parity_unit`

## Requirements
- R1: Byte k of the word occupies bits 9k+8 down to 9k (byte 0 is bits 8:0, byte 3 is bits 35:27), and bit 9k+8 is the parity bit of byte k.
- R2: With `odd_sel` = 1 (odd mode), a byte passes the check only when its nine bits hold an odd number of ones.
- R3: With `odd_sel` = 0 (even mode), a byte passes the check only when its nine bits hold an even number of ones.
- R4: `perr_n` is registered on the rising edge of `clk`. After an edge it is 0 if at least one of the four bytes on `din` failed before that edge, and 1 if all four passed.
- R5: With `gen_en` = 1, bit 9k+8 of `dout` is set so that byte k of `dout` meets the parity selected by `odd_sel`. The other eight bits of each byte equal those of `rd_data`.
- R6: With `gen_en` = 0, `dout` equals `rd_data` in all 36 bits, stored parity bits included.
- R7: When `dir_wr` = 0, `mbx_sel` = 1 and `gen_en` = 1 before a rising edge, `perr_n` is 1 after that edge, whatever is on `din`.
- R8: If any one of those three conditions is absent (`dir_wr` = 1, or `mbx_sel` = 0, or `gen_en` = 0), checking of `din` proceeds as in R4.
- R9: While `rst_n` is 0, `perr_n` is 1. After `rst_n` rises, `perr_n` stays 1 through the first rising edge and follows R4 from the third rising edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| dir_wr | input | 1 | 1 sets the port to write (data in), 0 sets it to read (data out) |
| mbx_sel | input | 1 | 1 selects the mailbox path instead of the queue |
| gen_en | input | 1 | 1 enables parity generation on outgoing read data |
| din | input | 36 | Word arriving on the port pins, to be checked |
| rd_data | input | 36 | Word to be sent out (queue or mailbox read data) |
| dout | output | 36 | Outgoing word, with generated parity bits when enabled |
| perr_n | output | 1 | Registered parity error flag, low when a byte failed |

## Verification
The properties assume that the selects and both data words are known values that stay stable around each rising edge of `clk`. They also assume that the mailbox-read condition is decided by the inputs present just before an edge. The bench drives every input on the falling edge and only samples `perr_n` at the next falling edge, so no change coincides with a clock edge. The bench also releases reset with a clean low-to-high step, which keeps the synchronizer out of an unknown state.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int unsigned BPU_NUM_BYTES = 4;
  localparam int unsigned BPU_BYTE_W    = 9;

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_mode_e;
endpackage

// File: rtl/bpu_rst_sync.sv
module bpu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;
endmodule

// File: rtl/bpu_parity_tree.sv
module bpu_parity_tree #(
  parameter int unsigned NUM_BYTES = bpu_pkg::BPU_NUM_BYTES,
  parameter int unsigned BYTE_W    = bpu_pkg::BPU_BYTE_W,
  localparam int unsigned WORD_W   = NUM_BYTES * BYTE_W,
  localparam int unsigned DATA_W   = BYTE_W - 1
) (
  input  logic [WORD_W-1:0]    word,
  input  bpu_pkg::par_mode_e   mode,
  output logic [NUM_BYTES-1:0] gen_bit,
  output logic [NUM_BYTES-1:0] chk_fail
);
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    logic [DATA_W-1:0] payload;
    logic              stored;
    logic              pay_xor;

    assign payload = word[k*BYTE_W +: DATA_W];
    assign stored  = word[k*BYTE_W + DATA_W];
    assign pay_xor = ^payload;

    // odd mode wants the total of ones to be odd, so the generated bit
    // is the inverse of the payload xor; even mode uses it directly
    assign gen_bit[k]  = pay_xor ^ (mode == bpu_pkg::PAR_ODD);
    assign chk_fail[k] = pay_xor ^ stored ^ (mode == bpu_pkg::PAR_ODD);
  end
endmodule

// File: rtl/bpu_gen_merge.sv
module bpu_gen_merge #(
  parameter int unsigned NUM_BYTES = bpu_pkg::BPU_NUM_BYTES,
  parameter int unsigned BYTE_W    = bpu_pkg::BPU_BYTE_W,
  localparam int unsigned WORD_W   = NUM_BYTES * BYTE_W,
  localparam int unsigned DATA_W   = BYTE_W - 1
) (
  input  logic [WORD_W-1:0]    rd_word,
  input  logic [NUM_BYTES-1:0] par_bits,
  input  logic                 gen_en,
  output logic [WORD_W-1:0]    out_word
);
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    always_comb begin
      out_word[k*BYTE_W +: DATA_W] = rd_word[k*BYTE_W +: DATA_W];
      if (gen_en) begin
        out_word[k*BYTE_W + DATA_W] = par_bits[k];
      end else begin
        out_word[k*BYTE_W + DATA_W] = rd_word[k*BYTE_W + DATA_W];
      end
    end
  end
endmodule

// File: rtl/bpu_flag_reg.sv
module bpu_flag_reg #(
  parameter int unsigned NUM_BYTES = bpu_pkg::BPU_NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_q_n,
  input  logic                 hold_clear,
  input  logic [NUM_BYTES-1:0] fail,
  output logic                 flag_n
);
  logic flag_d;
  logic flag_q;

  always_comb begin
    if (hold_clear) begin
      flag_d = 1'b1;
    end else begin
      flag_d = ~(|fail);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flag_q <= 1'b1;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_n = flag_q;
endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit #(
  parameter int unsigned NUM_BYTES = bpu_pkg::BPU_NUM_BYTES,
  parameter int unsigned BYTE_W    = bpu_pkg::BPU_BYTE_W,
  localparam int unsigned WORD_W   = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd_sel,
  input  logic              dir_wr,
  input  logic              mbx_sel,
  input  logic              gen_en,
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] dout,
  output logic              perr_n
);
  bpu_pkg::par_mode_e    mode;
  logic                  rst_q_n;
  logic                  share;
  logic [WORD_W-1:0]     shared_src;
  logic [NUM_BYTES-1:0]  sh_gen;
  logic [NUM_BYTES-1:0]  sh_fail;
  logic [NUM_BYTES-1:0]  q_gen;
  logic [NUM_BYTES-1:0]  unused_q_fail;
  logic [NUM_BYTES-1:0]  par_sel;

  assign mode = odd_sel ? bpu_pkg::PAR_ODD : bpu_pkg::PAR_EVEN;

  // mailbox read with generation: the shared trees work on the outgoing word
  assign share      = ~dir_wr & mbx_sel & gen_en;
  assign shared_src = share ? rd_data : din;

  bpu_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bpu_parity_tree #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_tree_shared (
    .word     (shared_src),
    .mode     (mode),
    .gen_bit  (sh_gen),
    .chk_fail (sh_fail)
  );

  bpu_parity_tree #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_tree_queue (
    .word     (rd_data),
    .mode     (mode),
    .gen_bit  (q_gen),
    .chk_fail (unused_q_fail)
  );

  assign par_sel = share ? sh_gen : q_gen;

  bpu_gen_merge #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_merge (
    .rd_word  (rd_data),
    .par_bits (par_sel),
    .gen_en   (gen_en),
    .out_word (dout)
  );

  bpu_flag_reg #(.NUM_BYTES(NUM_BYTES)) u_flag (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .hold_clear (share),
    .fail       (sh_fail),
    .flag_n     (perr_n)
  );
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
  parameter int unsigned NUM_BYTES = bpu_pkg::BPU_NUM_BYTES,
  parameter int unsigned BYTE_W    = bpu_pkg::BPU_BYTE_W,
  localparam int unsigned WORD_W   = NUM_BYTES * BYTE_W
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              odd_sel,
  input logic              dir_wr,
  input logic              mbx_sel,
  input logic              gen_en,
  input logic [WORD_W-1:0] din,
  input logic [WORD_W-1:0] rd_data,
  input logic [WORD_W-1:0] dout,
  input logic              perr_n
);
  logic mbx_gen_read;
  logic any_bad;

  assign mbx_gen_read = (dir_wr == 1'b0) && (mbx_sel == 1'b1) && (gen_en == 1'b1);

  always_comb begin
    any_bad = 1'b0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (($countones(din[k*BYTE_W +: BYTE_W]) % 2 == 1) != odd_sel) any_bad = 1'b1;
    end
  end

  // R4 / R8: a failing byte outside the mailbox-read case pulls the flag low
  a_r4_fail_low: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mbx_gen_read && any_bad) |=> !perr_n);

  a_r4_pass_high: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mbx_gen_read && !any_bad) |=> perr_n);

  // R7: mailbox read with generation keeps the flag inactive
  a_r7_share_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    mbx_gen_read |=> perr_n);

  // R6: generation off leaves the word untouched
  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_q_n)
    !gen_en |-> (dout == rd_data));

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_chk
    // R5: each output byte meets the selected parity
    a_r5_gen_parity: assert property (@(posedge clk) disable iff (!rst_q_n)
      gen_en |-> (($countones(dout[k*BYTE_W +: BYTE_W]) % 2 == 1) == odd_sel));

    // R5: payload bits survive generation
    a_r5_payload_kept: assert property (@(posedge clk) disable iff (!rst_q_n)
      gen_en |-> (dout[k*BYTE_W +: BYTE_W-1] == rd_data[k*BYTE_W +: BYTE_W-1]));
  end
endmodule

bind byte_parity_unit bpu_checker #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_bpu_checker (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .odd_sel (odd_sel),
  .dir_wr  (dir_wr),
  .mbx_sel (mbx_sel),
  .gen_en  (gen_en),
  .din     (din),
  .rd_data (rd_data),
  .dout    (dout),
  .perr_n  (perr_n)
);

// File: tb/tb_byte_parity_unit.sv
module tb_byte_parity_unit;
  localparam int unsigned NB = 4;
  localparam int unsigned BW = 9;
  localparam int unsigned WW = NB * BW;
  localparam int unsigned NV = 14;

  // entry: {odd_sel, dir_wr, mbx_sel, gen_en, din[35:0], rd_data[35:0], exp_perr_n, req}
  localparam logic [80:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,1'b0, 36'h804020100, 36'h123456789, 1'b1, 4'd2},
    {1'b1,1'b1,1'b0,1'b0, 36'h000000000, 36'hFFFFFFFFF, 1'b0, 4'd2},
    {1'b0,1'b1,1'b0,1'b0, 36'h000000000, 36'h0F0F0F0F0, 1'b1, 4'd3},
    {1'b0,1'b1,1'b0,1'b0, 36'h804020100, 36'hABCDE0123, 1'b0, 4'd3},
    {1'b1,1'b1,1'b0,1'b0, 36'h800020100, 36'h123456789, 1'b0, 4'd4},
    {1'b1,1'b0,1'b1,1'b1, 36'h000000000, 36'h123456789, 1'b1, 4'd7},
    {1'b0,1'b0,1'b1,1'b1, 36'hFFFFFFFFF, 36'hABCDE0123, 1'b1, 4'd7},
    {1'b1,1'b1,1'b1,1'b1, 36'h000000000, 36'h0F0F0F0F0, 1'b0, 4'd8},
    {1'b1,1'b0,1'b0,1'b1, 36'h000000000, 36'h123456789, 1'b0, 4'd8},
    {1'b1,1'b0,1'b1,1'b0, 36'h000000000, 36'hABCDE0123, 1'b0, 4'd8},
    {1'b0,1'b1,1'b0,1'b1, 36'hFFFFFFFFF, 36'h000000000, 1'b0, 4'd5},
    {1'b1,1'b0,1'b0,1'b0, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 1'b1, 4'd6},
    {1'b0,1'b1,1'b0,1'b0, 36'h0000001FF, 36'h0F0F0F0F0, 1'b0, 4'd1},
    {1'b1,1'b1,1'b0,1'b1, 36'h804020100, 36'h000000000, 1'b1, 4'd5}
  };

  logic          clk;
  logic          rst_n;
  logic          odd_sel;
  logic          dir_wr;
  logic          mbx_sel;
  logic          gen_en;
  logic [WW-1:0] din;
  logic [WW-1:0] rd_data;
  logic [WW-1:0] dout;
  logic          perr_n;

  int checks;
  int failures;
  bit finished;

  byte_parity_unit dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .odd_sel (odd_sel),
    .dir_wr  (dir_wr),
    .mbx_sel (mbx_sel),
    .gen_en  (gen_en),
    .din     (din),
    .rd_data (rd_data),
    .dout    (dout),
    .perr_n  (perr_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: req_name = "R1";
      4'd2: req_name = "R2";
      4'd3: req_name = "R3";
      4'd4: req_name = "R4";
      4'd5: req_name = "R5";
      4'd6: req_name = "R6";
      4'd7: req_name = "R7";
      4'd8: req_name = "R8";
      default: req_name = "R9";
    endcase
  endfunction

  // expected outgoing word, built from the requirement text (R5, R6)
  function automatic logic [WW-1:0] model_dout(input logic [WW-1:0] rd, input logic ge,
                                               input logic od);
    logic [WW-1:0] w;
    w = rd;
    if (ge) begin
      for (int k = 0; k < NB; k++) begin
        int ones;
        ones = $countones(rd[k*BW +: BW-1]);
        w[k*BW + BW - 1] = ((ones % 2) == 0) ? od : !od;
      end
    end
    return w;
  endfunction

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s perr_n actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkw(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s dout actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks   = 0;
    failures = 0;
    finished = 1'b0;
    rst_n    = 1'b1;
    odd_sel  = 1'b1;
    dir_wr   = 1'b1;
    mbx_sel  = 1'b0;
    gen_en   = 1'b0;
    din      = '0;      // fails in odd mode
    rd_data  = '0;
    #1 rst_n = 1'b0;

    // R9: flag high throughout reset even with a failing byte on the pins
    repeat (3) @(negedge clk);
    check1("R9 in reset", perr_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R9 first edge after release", perr_n, 1'b1);
    repeat (2) @(negedge clk);
    check1("R9 tracks after release", perr_n, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [80:0] v;
      string tag;
      v = VEC[i];
      tag = req_name(v[3:0]);
      @(negedge clk);
      odd_sel = v[80];
      dir_wr  = v[79];
      mbx_sel = v[78];
      gen_en  = v[77];
      din     = v[76:41];
      rd_data = v[40:5];
      #1;
      checkw(tag, dout, model_dout(v[40:5], v[77], v[80]));
      @(negedge clk);
      check1(tag, perr_n, v[4]);
    end

    // R1: generated parity lands in bits 8, 17, 26, 35 of an all-zero word
    @(negedge clk);
    odd_sel = 1'b1; dir_wr = 1'b0; mbx_sel = 1'b0; gen_en = 1'b1;
    rd_data = '0; din = 36'h804020100;
    #1 checkw("R1 parity positions", dout, 36'h804020100);

    // R1: a single bad byte at the top of the word is found
    @(negedge clk);
    dir_wr = 1'b1; gen_en = 1'b0; din = 36'h004020100;
    @(negedge clk);
    check1("R1 byte3 fail", perr_n, 1'b0);

    // R7 then R8: same failing pins, flag follows the sharing condition
    @(negedge clk);
    dir_wr = 1'b0; mbx_sel = 1'b1; gen_en = 1'b1; din = '0;
    @(negedge clk);
    check1("R7 held high", perr_n, 1'b1);
    dir_wr = 1'b1;
    @(negedge clk);
    check1("R8 check resumes", perr_n, 1'b0);

    // R5: mailbox generation in even mode
    odd_sel = 1'b0; dir_wr = 1'b0; rd_data = 36'h0FF0FF001;
    #1 checkw("R5 even mailbox gen", dout, model_dout(36'h0FF0FF001, 1'b1, 1'b0));

    // R9: asynchronous assertion forces the flag high at once
    @(negedge clk);
    dir_wr = 1'b1; mbx_sel = 1'b0; odd_sel = 1'b1; din = '0;
    @(negedge clk);
    check1("R4 low before reset", perr_n, 1'b0);
    #1 rst_n = 1'b0;
    #1 check1("R9 async reset", perr_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check1("R9 recovers", perr_n, 1'b0);

    finish_run();
  end
endmodule